// File: doc/BRIEF.md
# Edge-capture timer

A free-running counter peripheral with one compare channel and two edge-capture channels. All of it sits behind a plain single-cycle register port and drives one interrupt line. The counter runs either from the core clock or from an external oscillator tick divided by eight. It can wrap freely, or restart from zero after a compare match.

Each capture channel watches an asynchronous pin. The pin is synchronised, and then the channel looks for the transition that its 2-bit edge mode selects. On a qualifying transition the channel stores the current count and raises its own sticky flag. The compare flag and the two capture flags share one status map and one enable map. Software therefore masks each source and clears it with write-one-to-clear without touching the other flags. The interrupt line is high while any enabled flag is set.

Register offsets: control 0x00, status 0x08, interrupt enable 0x0C, compare 0x10, capture channel 0 at 0x1C, capture channel 1 at 0x20, counter 0x24. Writes commit on the clock edge. Read data is combinational and is zero while the read strobe is low.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset every register reads zero and irq_o is low.
- R2: Control keeps only bit 0 (enable), bits 8:6 (clock source), bit 9 (free-run), bits 17:16 (channel 0 edge mode) and bits 19:18 (channel 1 edge mode), so it reads back under mask 0x000F03C1. The interrupt enable keeps only bits 0, 3 and 4 (mask 0x19). Unmapped offsets read zero. Writes to the counter and capture offsets are ignored.
- R3: With enable set and clock source 2, the counter advances by one every clock. With enable clear, or with a source other than 2 or 5, it holds.
- R4: With clock source 5 the counter advances once per eight osc_tick pulses. The divider restarts whenever the timer is disabled or another source is selected.
- R5: When the counter equals the compare value on an advance, status bit 0 sets. With bit 9 set the counter continues upward. With bit 9 clear that advance loads zero instead.
- R6: In free-run mode the counter wraps from all ones to zero.
- R7: Edge mode 0 captures nothing, 1 captures rising transitions only, 2 captures falling transitions only and 3 captures both.
- R8: A qualifying transition stores the counter value of the cycle in which the synchronised edge is detected, two clocks after the pin changes. It also sets status bit 3 for channel 0 or bit 4 for channel 1, and no other flag.
- R9: Writing status clears exactly the flags whose data bits are 1. Other flags are unchanged.
- R10: A flag set event in the same cycle as a clearing write leaves the flag set.
- R11: A capture while the channel flag is already set overwrites the stored value and leaves the flag set.
- R12: irq_o is the OR of status AND interrupt enable over bits 0, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| cap_pin | input | 2 | Asynchronous capture pins, one per channel |
| osc_tick | input | 1 | One-cycle oscillator tick pulse, synchronous to clk |
| irq_o | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle:
- the counter steps by exactly one or holds, according to the control state;
- the compare flag only rises after a cycle where count and compare were equal;
- no flag falls without a clearing write naming it;
- a disabled capture channel never changes its stored value;
- the interrupt is never high with all flags clear.

Other behaviour can only be shown by the directed scenarios:
- the exact captured count for each edge mode, and the two-clock synchroniser latency;
- the divide-by-eight oscillator path, the restart-after-match value and the wrap;
- set-versus-clear priority, overwrite of a pending capture, and the field masks.

// File: rtl/ect_pkg.sv
package ect_pkg;

  localparam int NUM_CAP = 2;

  // register byte offsets
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_STAT = 'h08;
  localparam int OFS_IE   = 'h0C;
  localparam int OFS_CMP  = 'h10;
  localparam int OFS_CAP0 = 'h1C;
  localparam int OFS_CNT  = 'h24;
  localparam int CAP_STEP = 4;

  // control field positions
  localparam int CTL_EN      = 0;
  localparam int CTL_SRC_LO  = 6;
  localparam int CTL_FREE    = 9;
  localparam int CTL_MODE_LO = 16;

  // status / enable flag positions
  localparam int FLG_CMP    = 0;
  localparam int FLG_CAP_LO = 3;

  localparam logic [31:0] CTRL_MASK = 32'h000F_03C1;
  localparam logic [31:0] FLAG_MASK = 32'h0000_0019;

  localparam logic [2:0] SRC_CORE = 3'd2;
  localparam logic [2:0] SRC_OSC  = 3'd5;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

endpackage

// File: rtl/ect_rst_sync.sv
module ect_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_q = chain_q[STAGES-1];
endmodule

// File: rtl/ect_counter.sv
module ect_counter
  import ect_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int OSC_DIV = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [2:0]       src_i,
  input  logic             freerun_i,
  input  logic             osc_tick_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  localparam int DIV_W = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(OSC_DIV - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             osc_sel, tick;

  assign osc_sel = run_i && (src_i == SRC_OSC);
  assign tick    = (run_i && (src_i == SRC_CORE)) ||
                   (osc_sel && osc_tick_i && (div_q == DIV_LAST));
  assign match_o = tick && (cnt_q == cmp_i);

  always_comb begin
    div_d = div_q;
    if (!osc_sel)        div_d = '0;
    else if (osc_tick_i) div_d = (div_q == DIV_LAST) ? '0 : div_q + 1'b1;

    cnt_d = cnt_q;
    if (tick) cnt_d = (match_o && !freerun_i) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      if (tick) cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ect_capture_chan.sv
module ect_capture_chan
  import ect_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  edge_mode_e       mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             evt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   lvl, rise, fall, hit;
  logic [CNT_W-1:0]       cap_q, cap_d;

  assign lvl  = sync_q[SYNC_STAGES-1];
  assign rise = lvl && !prev_q;
  assign fall = !lvl && prev_q;

  always_comb begin
    unique case (mode_i)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise || fall;
      default:   hit = 1'b0;
    endcase
    cap_d = hit ? cnt_i : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= lvl;
      if (hit) cap_q <= cap_d;
    end
  end

  assign cap_o = cap_q;
  assign evt_o = hit;
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
  import ect_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int OSC_DIV     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_CAP-1:0] cap_pin,
  input  logic               osc_tick,
  output logic               irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_IE   = ADDR_W'(OFS_IE);
  localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(OFS_CMP);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);

  logic                          rst_n_q;
  logic [31:0]                   ctrl_q, ctrl_d, ie_q, ie_d, status_q, status_d;
  logic [31:0]                   set_vec, clr_vec, rd_val;
  logic [CNT_W-1:0]              cmp_q, cmp_d, cnt;
  logic                          ctrl_we, ie_we, cmp_we, stat_we, match;
  logic [NUM_CAP-1:0]            cap_evt;
  logic [NUM_CAP-1:0][CNT_W-1:0] cap_vals;

  ect_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_q (rst_n_q)
  );

  ect_counter #(.CNT_W(CNT_W), .OSC_DIV(OSC_DIV)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_q),
    .run_i      (ctrl_q[CTL_EN]),
    .src_i      (ctrl_q[CTL_SRC_LO +: 3]),
    .freerun_i  (ctrl_q[CTL_FREE]),
    .osc_tick_i (osc_tick),
    .cmp_i      (cmp_q),
    .cnt_o      (cnt),
    .match_o    (match)
  );

  for (genvar g = 0; g < NUM_CAP; g++) begin : g_cap
    ect_capture_chan #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n_q),
      .pin_i  (cap_pin[g]),
      .mode_i (edge_mode_e'(ctrl_q[CTL_MODE_LO + 2*g +: 2])),
      .cnt_i  (cnt),
      .cap_o  (cap_vals[g]),
      .evt_o  (cap_evt[g])
    );
  end

  // address decode and next state
  assign ctrl_we = bus_wr && (bus_addr == A_CTRL);
  assign ie_we   = bus_wr && (bus_addr == A_IE);
  assign cmp_we  = bus_wr && (bus_addr == A_CMP);
  assign stat_we = bus_wr && (bus_addr == A_STAT);

  always_comb begin
    ctrl_d  = bus_wdata & CTRL_MASK;
    ie_d    = bus_wdata & FLAG_MASK;
    cmp_d   = bus_wdata[CNT_W-1:0];
    set_vec = '0;
    set_vec[FLG_CMP] = match;
    for (int i = 0; i < NUM_CAP; i++) set_vec[FLG_CAP_LO + i] = cap_evt[i];
    clr_vec  = stat_we ? (bus_wdata & FLAG_MASK) : '0;
    // a new event wins over a clear in the same cycle
    status_d = (status_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      ctrl_q   <= '0;
      ie_q     <= '0;
      cmp_q    <= '0;
      status_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (ie_we)   ie_q   <= ie_d;
      if (cmp_we)  cmp_q  <= cmp_d;
      status_q <= status_d;
    end
  end

  // read port
  always_comb begin
    rd_val = '0;
    if (bus_addr == A_CTRL) rd_val = ctrl_q;
    if (bus_addr == A_STAT) rd_val = status_q;
    if (bus_addr == A_IE)   rd_val = ie_q;
    if (bus_addr == A_CMP)  rd_val = 32'(cmp_q);
    if (bus_addr == A_CNT)  rd_val = 32'(cnt);
    for (int i = 0; i < NUM_CAP; i++) begin
      if (bus_addr == ADDR_W'(OFS_CAP0 + CAP_STEP*i)) rd_val = 32'(cap_vals[i]);
    end
  end

  assign bus_rdata = bus_rd ? rd_val : '0;
  assign irq_o     = |(status_q & ie_q & FLAG_MASK);
endmodule

// File: rtl/ect_checker.sv
module ect_checker
  import ect_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic                          clk,
  input logic                          rst_n_q,
  input logic                          bus_wr,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [31:0]                   bus_wdata,
  input logic                          run,
  input logic [2:0]                    src,
  input logic                          freerun,
  input logic [1:0]                    mode0,
  input logic [1:0]                    mode1,
  input logic [31:0]                   status_q,
  input logic [CNT_W-1:0]              cnt,
  input logic [CNT_W-1:0]              cmp_q,
  input logic [NUM_CAP-1:0][CNT_W-1:0] cap_vals,
  input logic                          irq_o
);
  logic [31:0] clr_req;
  assign clr_req = (bus_wr && (bus_addr == ADDR_W'(OFS_STAT))) ? bus_wdata : '0;

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (run && (src == SRC_CORE) && freerun) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    !run |=> $stable(cnt));

  // R5
  cmp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    $rose(status_q[FLG_CMP]) |-> $past(cnt == cmp_q));

  // R7
  cap0_off_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (mode0 == 2'b00) |=> $stable(cap_vals[0]));

  // R7
  cap1_off_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (mode1 == 2'b00) |=> $stable(cap_vals[1]));

  // R9
  w1c_only_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    (($past(status_q) & ~status_q & ~$past(clr_req)) == 32'h0));

  // R12
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n_q)
    irq_o |-> (status_q != 32'h0));
endmodule

bind edge_capture_timer ect_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n_q   (rst_n_q),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .run       (ctrl_q[0]),
  .src       (ctrl_q[8:6]),
  .freerun   (ctrl_q[9]),
  .mode0     (ctrl_q[17:16]),
  .mode1     (ctrl_q[19:18]),
  .status_q  (status_q),
  .cnt       (cnt),
  .cmp_q     (cmp_q),
  .cap_vals  (cap_vals),
  .irq_o     (irq_o)
);

// File: tb/edge_capture_timer_tb.sv
`timescale 1ns/1ps
module edge_capture_timer_tb;
  localparam int W = 10;
  localparam logic [31:0] MASK = (32'h1 << W) - 1;

  logic        clk = 1'b0;
  logic        rst_n, bus_wr, bus_rd, osc_tick, irq_o;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  cap_pin;
  int          n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  edge_capture_timer #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_pin(cap_pin), .osc_tick(osc_tick), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic osc_pulse(input int n);
    repeat (n) begin
      @(negedge clk); osc_tick = 1'b1;
      @(negedge clk); osc_tick = 1'b0;
    end
  endtask

  // drive one capture pin and check stored value and flag
  task automatic cap_edge(input int ch, input logic lvl, input bit hit, input int adv, input string req);
    logic [31:0] old_cap, old_st, c0, v, fbit;
    logic [7:0]  ca;
    ca   = (ch == 0) ? 8'h1C : 8'h20;
    fbit = (ch == 0) ? 32'h08 : 32'h10;
    bus_read(ca, old_cap);
    bus_read(8'h08, old_st);
    @(negedge clk);
    bus_addr = 8'h24; bus_rd = 1'b1; cap_pin[ch] = lvl;
    #1 c0 = bus_rdata;
    bus_rd = 1'b0;
    wait_cyc(4);
    bus_read(ca, v);
    check(req, v, hit ? ((c0 + adv) & MASK) : old_cap);
    bus_read(8'h08, v);
    check(req, v & 32'h18, hit ? ((old_st | fbit) & 32'h18) : (old_st & 32'h18));
  endtask

  task automatic t_reset;
    logic [31:0] v;
    bus_read(8'h00, v); check("R1 ctrl", v, 0);
    bus_read(8'h08, v); check("R1 status", v, 0);
    bus_read(8'h0C, v); check("R1 ie", v, 0);
    bus_read(8'h10, v); check("R1 cmp", v, 0);
    bus_read(8'h1C, v); check("R1 cap0", v, 0);
    bus_read(8'h20, v); check("R1 cap1", v, 0);
    bus_read(8'h24, v); check("R1 cnt", v, 0);
    check("R1 irq", 32'(irq_o), 0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_read(8'h00, v); check("R2 ctrl mask", v, 32'h000F_03C1);
    bus_write(8'h0C, 32'hFFFF_FFFF);
    bus_read(8'h0C, v); check("R2 ie mask", v, 32'h19);
    bus_read(8'h04, v); check("R2 unmapped", v, 0);
    bus_write(8'h24, 32'h55);
    bus_read(8'h24, v); check("R2 cnt read-only", v, 0);
    bus_write(8'h1C, 32'h77);
    bus_read(8'h1C, v); check("R2 cap read-only", v, 0);
    bus_write(8'h00, 0);
    bus_write(8'h0C, 0);
  endtask

  task automatic t_count;
    logic [31:0] a, b;
    bus_write(8'h00, 32'h281);
    bus_read(8'h24, a); wait_cyc(5); bus_read(8'h24, b);
    check("R3 advance", b, (a + 6) & MASK);
    bus_write(8'h00, 32'h280);
    bus_read(8'h24, a); wait_cyc(5); bus_read(8'h24, b);
    check("R3 hold disabled", b, a);
    bus_write(8'h00, 32'h201);
    bus_read(8'h24, a); wait_cyc(5); bus_read(8'h24, b);
    check("R3 hold bad source", b, a);
  endtask

  task automatic t_osc;
    logic [31:0] a, b;
    bus_write(8'h00, 32'h341);
    bus_read(8'h24, a);
    osc_pulse(8);  bus_read(8'h24, b); check("R4 eighth pulse", b, (a + 1) & MASK);
    osc_pulse(7);  bus_read(8'h24, b); check("R4 partial", b, (a + 1) & MASK);
    osc_pulse(1);  bus_read(8'h24, b); check("R4 second tick", b, (a + 2) & MASK);
    bus_write(8'h00, 32'h200);
  endtask

  task automatic t_compare;
    logic [31:0] v, c;
    bus_write(8'h08, 32'h19);
    bus_read(8'h24, v);
    bus_write(8'h10, (v + 3) & MASK);
    bus_write(8'h00, 32'h281);
    wait_cyc(8);
    bus_read(8'h08, c); check("R5 flag free-run", c & 1, 1);
    bus_read(8'h24, c); check("R5 free-run continues", c, (v + 9) & MASK);
    bus_write(8'h00, 32'h200);
    bus_write(8'h08, 32'h01);
    bus_read(8'h08, c); check("R9 clear cmp flag", c & 1, 0);
    bus_read(8'h24, v);
    bus_write(8'h10, (v + 3) & MASK);
    bus_write(8'h00, 32'h081);
    wait_cyc(8);
    bus_read(8'h08, c); check("R5 flag restart", c & 1, 1);
    bus_read(8'h24, c); check("R5 restart to zero", c, 5);
    bus_write(8'h00, 32'h200);
    bus_write(8'h08, 32'h01);
  endtask

  task automatic t_wrap;
    logic [31:0] a, b;
    bus_write(8'h00, 32'h281);
    bus_read(8'h24, a); wait_cyc(1100); bus_read(8'h24, b);
    check("R6 wrap", b, (a + 1101) & MASK);
  endtask

  task automatic t_modes;
    bus_write(8'h08, 32'h19);
    bus_write(8'h00, 32'h10281);
    cap_edge(0, 1'b1, 1, 2, "R8 rise latency");
    cap_edge(0, 1'b0, 0, 2, "R7 rise mode ignores fall");
    bus_write(8'h00, 32'h20281);
    cap_edge(0, 1'b1, 0, 2, "R7 fall mode ignores rise");
    cap_edge(0, 1'b0, 1, 2, "R7 fall mode");
    bus_write(8'h00, 32'h30281);
    cap_edge(0, 1'b1, 1, 2, "R7 both rise");
    cap_edge(0, 1'b0, 1, 2, "R7 both fall");
    bus_write(8'h00, 32'h00281);
    cap_edge(0, 1'b1, 0, 2, "R7 off rise");
    cap_edge(0, 1'b0, 0, 2, "R7 off fall");
  endtask

  task automatic t_chan1;
    logic [31:0] v;
    bus_write(8'h08, 32'h19);
    bus_write(8'h00, 32'hC0281);
    cap_edge(1, 1'b1, 1, 2, "R8 channel 1");
    bus_read(8'h08, v); check("R8 only bit 4", v & 32'h18, 32'h10);
    cap_edge(1, 1'b0, 1, 2, "R7 channel 1 both");
  endtask

  task automatic t_w1c;
    logic [31:0] v, c0;
    bus_write(8'h00, 32'hF0281);
    cap_edge(0, 1'b1, 1, 2, "R8 channel 0");
    bus_write(8'h08, 32'h08);
    bus_read(8'h08, v); check("R9 selective clear", v & 32'h18, 32'h10);
    bus_write(8'h08, 32'h00);
    bus_read(8'h08, v); check("R9 zero write", v & 32'h18, 32'h10);
    cap_edge(0, 1'b0, 1, 2, "R8 channel 0 again");
    // R10: clear lands in the same cycle as a new capture
    @(negedge clk);
    bus_addr = 8'h24; bus_rd = 1'b1; cap_pin[0] = 1'b1;
    #1 c0 = bus_rdata;
    bus_rd = 1'b0;
    @(negedge clk);
    bus_write(8'h08, 32'h08);
    bus_read(8'h08, v); check("R10 set beats clear", v & 32'h08, 32'h08);
    bus_read(8'h1C, v); check("R10 value stored", v, (c0 + 2) & MASK);
    cap_edge(0, 1'b0, 1, 2, "R11 overwrite with flag set");
  endtask

  task automatic t_irq;
    bus_write(8'h00, 32'hF0280);
    bus_write(8'h08, 32'h19);
    bus_write(8'h0C, 32'h08);
    cap_edge(1, ~cap_pin[1], 1, 0, "R12 setup ch1");
    check("R12 masked flag", 32'(irq_o), 0);
    cap_edge(0, ~cap_pin[0], 1, 0, "R12 setup ch0");
    check("R12 enabled flag", 32'(irq_o), 1);
    bus_write(8'h08, 32'h08);
    @(negedge clk); check("R12 after clear", 32'(irq_o), 0);
    bus_write(8'h0C, 32'h10);
    @(negedge clk); check("R12 other enable", 32'(irq_o), 1);
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; osc_tick = 1'b0;
    bus_addr = '0; bus_wdata = '0; cap_pin = '0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_regs();
    t_count();
    t_osc();
    t_compare();
    t_wrap();
    t_modes();
    t_chan1();
    t_w1c();
    t_irq();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule